// File: doc/BRIEF.md
# Partial-Write Integer Register File

This block holds sixteen 64-bit integer registers behind one write port and two read ports. Each port names a register, an access width and whether the access targets the second byte lane. A write's effect on a register depends on its width. A full-width write replaces the whole register. A 32-bit write stores the low half and clears the high half. A 16-bit write, a low-byte write or a second-byte write changes only its own lane and keeps every other bit.

Reads are combinational from the stored state. They return the selected lane shifted down to bit 0, with zeros above it. A read that names the register being written in the same cycle returns the value held before that write. The second-byte lane (bits 15:8) exists only for the first four registers. A request that asks for it on any other register, or with any width other than byte, is illegal. An illegal request raises that port's error output, and an illegal write leaves the storage unchanged. The block is meant to sit in an execution pipeline, where the decoder drives width codes taken straight from the instruction.

Top module: `partial_rf`

## Requirements
- R1: A synchronous active-high reset clears all sixteen registers to zero.
- R2: A write with size code 11 (64-bit) stores all 64 data bits into the indexed register.
- R3: A write with size code 10 (32-bit) stores data bits 31:0 into bits 31:0 and forces bits 63:32 to zero.
- R4: A write with size code 01 (16-bit) replaces bits 15:0 and leaves bits 63:16 unchanged.
- R5: A write with size code 00 and the high-byte select low replaces bits 7:0 only. This is legal on all sixteen registers.
- R6: A write with size code 00 and the high-byte select high, on registers 0 to 3, replaces bits 15:8 only. A matching read returns bits 15:8 in bits 7:0 of the read data.
- R7: Read data is the selected lane right-aligned and zero-extended. Size 11 gives bits 63:0, 10 gives bits 31:0, 01 gives bits 15:0, and 00 gives bits 7:0, or bits 15:8 when the high-byte select is set.
- R8: A high-byte request on registers 4 to 15 is illegal. On the write port it asserts the write error and leaves every register unchanged. On a read port it asserts that port's error and returns zero data.
- R9: The high-byte select combined with any size code other than 00 is illegal on every register. It is reported and suppressed as in R8.
- R10: While the write enable is low, no register changes and the write error stays low.
- R11: A read that addresses the register being written in the same cycle returns the pre-write value.
- R12: The two read ports decode their index, size and high-byte select independently of each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request valid |
| wr_idx | input | 4 | Register written |
| wr_size | input | 2 | Write width code (00 byte, 01 16-bit, 10 32-bit, 11 64-bit) |
| wr_hi | input | 1 | Write targets bits 15:8 (byte width only) |
| wr_data | input | 64 | Write value, lane right-aligned |
| wr_err | output | 1 | Illegal write request, write dropped |
| rd0_idx | input | 4 | Register read on port 0 |
| rd0_size | input | 2 | Port 0 width code |
| rd0_hi | input | 1 | Port 0 reads bits 15:8 |
| rd0_data | output | 64 | Port 0 read value, zero-extended |
| rd0_err | output | 1 | Port 0 request illegal |
| rd1_idx | input | 4 | Register read on port 1 |
| rd1_size | input | 2 | Port 1 width code |
| rd1_hi | input | 1 | Port 1 reads bits 15:8 |
| rd1_data | output | 64 | Port 1 read value, zero-extended |
| rd1_err | output | 1 | Port 1 request illegal |

## Verification
The assertions assume that the control inputs never carry unknown values once reset has been released. They also assume that reset is held for at least one rising edge before any write is checked, since the merge properties compare against the previous stored value. The bench drives every input from known values at the falling edge and holds reset across two edges at the start. It then sweeps every register against every width and high-byte combination, legal and illegal, on top of an all-ones background. That background makes any wrongly kept or wrongly cleared bit visible in the read-back.

// File: rtl/rf_pkg.sv
package rf_pkg;

    // Access width codes, as decoded from the instruction.
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_FULL = 2'b11
    } acc_size_e;

    // Mode of one port access: width plus the second-byte lane select.
    typedef struct packed {
        acc_size_e size;
        logic      hi;
    } acc_mode_t;

    // Lane widths of the narrow accesses.
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned HALF_W = 16;
    localparam int unsigned WORD_W = 32;

    function automatic acc_mode_t make_mode(input logic [1:0] size_code, input logic hi_sel);
        acc_mode_t m;
        m.size = acc_size_e'(size_code);
        m.hi   = hi_sel;
        return m;
    endfunction

endpackage

// File: rtl/rf_access_check.sv
module rf_access_check
    import rf_pkg::*;
#(
    parameter int unsigned NREG    = 16,
    parameter int unsigned HI_REGS = 4,
    localparam int unsigned IDXW   = $clog2(NREG)
) (
    input  logic [IDXW-1:0] idx,
    input  acc_mode_t       mode,
    output logic            illegal
);

    logic hi_wrong_size;
    logic hi_wrong_reg;

    always_comb begin
        hi_wrong_size = mode.hi && (mode.size != SZ_BYTE);
        hi_wrong_reg  = mode.hi && (idx >= IDXW'(HI_REGS));
        illegal       = hi_wrong_size || hi_wrong_reg;
    end

endmodule

// File: rtl/rf_write_merge.sv
module rf_write_merge
    import rf_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] wdata,
    input  acc_mode_t       mode,
    output logic [XLEN-1:0] new_val
);

    always_comb begin
        new_val = old_val;
        unique case (mode.size)
            SZ_FULL: new_val = wdata;
            SZ_WORD: new_val = {{(XLEN-WORD_W){1'b0}}, wdata[WORD_W-1:0]};
            SZ_HALF: new_val[HALF_W-1:0] = wdata[HALF_W-1:0];
            SZ_BYTE: begin
                if (mode.hi) begin
                    new_val[HALF_W-1:BYTE_W] = wdata[BYTE_W-1:0];
                end else begin
                    new_val[BYTE_W-1:0] = wdata[BYTE_W-1:0];
                end
            end
            default: new_val = old_val;
        endcase
    end

endmodule

// File: rtl/rf_read_align.sv
module rf_read_align
    import rf_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic [XLEN-1:0] word,
    input  acc_mode_t       mode,
    input  logic            illegal,
    output logic [XLEN-1:0] rdata
);

    always_comb begin
        rdata = '0;
        if (!illegal) begin
            unique case (mode.size)
                SZ_FULL: rdata = word;
                SZ_WORD: rdata[WORD_W-1:0] = word[WORD_W-1:0];
                SZ_HALF: rdata[HALF_W-1:0] = word[HALF_W-1:0];
                SZ_BYTE: begin
                    if (mode.hi) begin
                        rdata[BYTE_W-1:0] = word[HALF_W-1:BYTE_W];
                    end else begin
                        rdata[BYTE_W-1:0] = word[BYTE_W-1:0];
                    end
                end
                default: rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/partial_rf.sv
module partial_rf
    import rf_pkg::*;
#(
    parameter int unsigned XLEN    = 64,
    parameter int unsigned NREG    = 16,
    parameter int unsigned HI_REGS = 4,
    localparam int unsigned IDXW   = $clog2(NREG),
    localparam int unsigned NRD    = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [1:0]      wr_size,
    input  logic            wr_hi,
    input  logic [XLEN-1:0] wr_data,
    output logic            wr_err,
    input  logic [IDXW-1:0] rd0_idx,
    input  logic [1:0]      rd0_size,
    input  logic            rd0_hi,
    output logic [XLEN-1:0] rd0_data,
    output logic            rd0_err,
    input  logic [IDXW-1:0] rd1_idx,
    input  logic [1:0]      rd1_size,
    input  logic            rd1_hi,
    output logic [XLEN-1:0] rd1_data,
    output logic            rd1_err
);

    // Register storage, packed so it can be cleared and compared as a whole.
    logic [NREG-1:0][XLEN-1:0] regs_q;

    // ---------------- write path ----------------
    acc_mode_t       wr_mode;
    logic            wr_illegal;
    logic [XLEN-1:0] wr_merged;

    assign wr_mode = make_mode(wr_size, wr_hi);

    rf_access_check #(.NREG(NREG), .HI_REGS(HI_REGS)) wr_chk_u (
        .idx     (wr_idx),
        .mode    (wr_mode),
        .illegal (wr_illegal)
    );

    rf_write_merge #(.XLEN(XLEN)) wr_merge_u (
        .old_val (regs_q[wr_idx]),
        .wdata   (wr_data),
        .mode    (wr_mode),
        .new_val (wr_merged)
    );

    assign wr_err = wr_en && wr_illegal;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else if (wr_en && !wr_illegal) begin
            regs_q[wr_idx] <= wr_merged;
        end
    end

    // ---------------- read paths ----------------
    logic [IDXW-1:0] rp_idx  [NRD];
    logic [1:0]      rp_size [NRD];
    logic            rp_hi   [NRD];
    logic [XLEN-1:0] rp_data [NRD];
    logic            rp_err  [NRD];

    assign rp_idx[0]  = rd0_idx;
    assign rp_size[0] = rd0_size;
    assign rp_hi[0]   = rd0_hi;
    assign rp_idx[1]  = rd1_idx;
    assign rp_size[1] = rd1_size;
    assign rp_hi[1]   = rd1_hi;

    for (genvar p = 0; p < NRD; p++) begin : g_rdport
        acc_mode_t mode_p;
        logic      ill_p;

        assign mode_p = make_mode(rp_size[p], rp_hi[p]);

        rf_access_check #(.NREG(NREG), .HI_REGS(HI_REGS)) rd_chk_u (
            .idx     (rp_idx[p]),
            .mode    (mode_p),
            .illegal (ill_p)
        );

        // Storage read before the edge: a same-cycle write is not visible.
        rf_read_align #(.XLEN(XLEN)) rd_align_u (
            .word    (regs_q[rp_idx[p]]),
            .mode    (mode_p),
            .illegal (ill_p),
            .rdata   (rp_data[p])
        );

        assign rp_err[p] = ill_p;
    end

    assign rd0_data = rp_data[0];
    assign rd0_err  = rp_err[0];
    assign rd1_data = rp_data[1];
    assign rd1_err  = rp_err[1];

endmodule

// File: rtl/partial_rf_chk.sv
module partial_rf_chk #(
    parameter int unsigned XLEN    = 64,
    parameter int unsigned NREG    = 16,
    parameter int unsigned HI_REGS = 4,
    localparam int unsigned IDXW   = $clog2(NREG)
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      wr_en,
    input logic [IDXW-1:0]           wr_idx,
    input logic [1:0]                wr_size,
    input logic                      wr_hi,
    input logic [XLEN-1:0]           wr_data,
    input logic                      wr_err,
    input logic [IDXW-1:0]           rd0_idx,
    input logic [1:0]                rd0_size,
    input logic                      rd0_hi,
    input logic [XLEN-1:0]           rd0_data,
    input logic                      rd0_err,
    input logic [NREG-1:0][XLEN-1:0] regs_q
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (regs_q == '0));

    // R3
    word_write_zext_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_err && wr_size == 2'b10)
        |=> regs_q[$past(wr_idx)] == {{(XLEN-32){1'b0}}, $past(wr_data[31:0])});

    // R4
    half_write_keeps_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_err && wr_size == 2'b01)
        |=> regs_q[$past(wr_idx)][XLEN-1:16] == $past(regs_q[wr_idx][XLEN-1:16]));

    // R8
    hi_on_upper_reg_err_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_hi && wr_idx >= IDXW'(HI_REGS)) |-> wr_err);

    // R9
    hi_wrong_size_err_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_hi && wr_size != 2'b00) |-> wr_err);

    // R8
    bad_write_no_change_chk: assert property (@(posedge clk) disable iff (rst)
        wr_err |=> $stable(regs_q));

    // R10
    idle_no_change_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regs_q));

    // R10
    idle_no_err_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> !wr_err);

    // R8
    bad_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd0_err |-> (rd0_data == '0));

    // R7
    byte_read_narrow_chk: assert property (@(posedge clk) disable iff (rst)
        (rd0_size == 2'b00) |-> (rd0_data[XLEN-1:8] == '0));

endmodule

bind partial_rf partial_rf_chk #(
    .XLEN    (XLEN),
    .NREG    (NREG),
    .HI_REGS (HI_REGS)
) chk_i (.*);

// File: tb/partial_rf_tb_top.sv
module partial_rf_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [1:0]  wr_size = '0;
    logic        wr_hi = 1'b0;
    logic [63:0] wr_data = '0;
    logic        wr_err;
    logic [3:0]  rd0_idx = '0;
    logic [1:0]  rd0_size = 2'b11;
    logic        rd0_hi = 1'b0;
    logic [63:0] rd0_data;
    logic        rd0_err;
    logic [3:0]  rd1_idx = '0;
    logic [1:0]  rd1_size = 2'b11;
    logic        rd1_hi = 1'b0;
    logic [63:0] rd1_data;
    logic        rd1_err;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [63:0] model [16];

    always #5 clk = ~clk;

    partial_rf dut_i (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_hi(wr_hi),
        .wr_data(wr_data), .wr_err(wr_err),
        .rd0_idx(rd0_idx), .rd0_size(rd0_size), .rd0_hi(rd0_hi),
        .rd0_data(rd0_data), .rd0_err(rd0_err),
        .rd1_idx(rd1_idx), .rd1_size(rd1_size), .rd1_hi(rd1_hi),
        .rd1_data(rd1_data), .rd1_err(rd1_err)
    );

    function automatic bit is_legal(input int idx, input int sz, input bit hi);
        if (!hi) return 1'b1;
        return (sz == 0) && (idx < 4);
    endfunction

    function automatic logic [63:0] lane_mask(input int sz);
        if (sz == 3) return 64'hFFFF_FFFF_FFFF_FFFF;
        return (64'd1 << (8 << sz)) - 64'd1;
    endfunction

    function automatic logic [63:0] exp_read(input logic [63:0] v, input int idx,
                                             input int sz, input bit hi);
        if (!is_legal(idx, sz, hi)) return 64'd0;
        return (v >> (hi ? 8 : 0)) & lane_mask(sz);
    endfunction

    function automatic logic [63:0] exp_write(input logic [63:0] old, input logic [63:0] d,
                                              input int sz, input bit hi);
        logic [63:0] m;
        if (sz == 2) return d & 64'h0000_0000_FFFF_FFFF;
        m = lane_mask(sz) << (hi ? 8 : 0);
        return (old & ~m) | ((d << (hi ? 8 : 0)) & m);
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check reads against the pre-write
    // model, then let the rising edge commit and update the model.
    task automatic cyc(input string tag,
                       input bit we, input int wi, input int ws, input bit wh,
                       input logic [63:0] wd,
                       input int r0i, input int r0s, input bit r0h,
                       input int r1i, input int r1s, input bit r1h);
        @(negedge clk);
        wr_en = we; wr_idx = 4'(wi); wr_size = 2'(ws); wr_hi = wh; wr_data = wd;
        rd0_idx = 4'(r0i); rd0_size = 2'(r0s); rd0_hi = r0h;
        rd1_idx = 4'(r1i); rd1_size = 2'(r1s); rd1_hi = r1h;
        #1;
        check(tag, "rd0_data", rd0_data, exp_read(model[r0i], r0i, r0s, r0h));
        check(tag, "rd0_err", 64'(rd0_err), 64'(!is_legal(r0i, r0s, r0h)));
        check(tag, "rd1_data", rd1_data, exp_read(model[r1i], r1i, r1s, r1h));
        check(tag, "rd1_err", 64'(rd1_err), 64'(!is_legal(r1i, r1s, r1h)));
        check(tag, "wr_err", 64'(wr_err), 64'(we && !is_legal(wi, ws, wh)));
        @(posedge clk);
        if (we && is_legal(wi, ws, wh)) model[wi] = exp_write(model[wi], wd, ws, wh);
    endtask

    function automatic string tag_for(input int idx, input int sz, input bit hi);
        if (hi && sz != 0) return "R9";
        if (hi && idx >= 4) return "R8";
        if (hi) return "R6";
        case (sz)
            3: return "R2";
            2: return "R3";
            1: return "R4";
            default: return "R5";
        endcase
    endfunction

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: every register reads zero after reset
        for (int i = 0; i < 16; i += 2)
            cyc("R1", 0, 0, 3, 0, '0, i, 3, 0, i + 1, 3, 0);

        // Main sweep over register, width and high-byte select
        for (int i = 0; i < 16; i++) begin
            for (int s = 0; s < 4; s++) begin
                for (int h = 0; h < 2; h++) begin
                    logic [63:0] d;
                    d = 64'hA5C3_1E7F_0246_8BDF ^ (64'(i) * 64'h0101_0101_0101_0101)
                        ^ (64'(s * 2 + h) << 40);
                    // all-ones background
                    cyc("R2", 1, i, 3, 0, 64'hFFFF_FFFF_FFFF_FFFF, i, 3, 0, (i + 1) % 16, 3, 0);
                    // R11: same-cycle read sees the old value
                    cyc("R11", 1, i, s, h[0], d, i, 3, 0, i, s, h[0]);
                    // read back at every width on both ports (R7, R12)
                    for (int rs = 0; rs < 4; rs++) begin
                        cyc(tag_for(i, s, h[0]), 0, 0, 0, 0, d, i, rs, 0, i, 3 - rs, 0);
                        cyc("R7", 0, 0, 0, 0, d, i, rs, 1, (i + 5) % 16, rs, 0);
                    end
                end
            end
        end

        // R10: enable low with live data changes nothing
        cyc("R10", 1, 2, 3, 0, 64'h1122_3344_5566_7788, 2, 3, 0, 3, 3, 0);
        cyc("R10", 0, 2, 3, 0, 64'hDEAD_BEEF_DEAD_BEEF, 2, 3, 0, 2, 0, 1);
        cyc("R10", 0, 2, 0, 1, 64'h0, 2, 3, 0, 2, 1, 0);

        // R12: distinct registers and modes on the two ports
        cyc("R12", 0, 0, 0, 0, '0, 2, 0, 1, 15, 2, 0);
        cyc("R12", 0, 0, 0, 0, '0, 15, 0, 1, 2, 1, 0);

        // R1: reset in mid-run clears the contents
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 16; i++) model[i] = '0;
        for (int i = 0; i < 16; i += 2)
            cyc("R1", 0, 0, 3, 0, '0, i, 3, 0, i + 1, 3, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule